// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-sliced ports, A and B, through a transceiver that is split into independent halves. Each half has its own active-low output enable and its own direction input. When the enable is low, the direction picks which port the half drives. Each half also has two storage registers, one for each direction. The A-to-B register loads the A port and the B-to-A register loads the B port. Each register has its own capture strobe, and loading happens at a rising edge of the system clock on which that strobe is high.

A per-direction source select picks what the driven port shows. With the select low it shows live data from the opposite port, passed through combinationally. With the select high it shows the word held in that direction's register. Capture does not depend on the output controls. A word can therefore be stored while the half is isolated, or while the opposite port is being driven, and replayed onto the bus later.

Each bidirectional pin group is modelled as an input vector, an output vector and one drive-enable bit per half. Whatever sits around the block resolves these into the physical bus.

Top module: `xcvr_bidir_top`

## Requirements
- R1: While `rst` is high at a clock edge, both registers of every half load zero. After reset and before any capture, stored-mode output is therefore all zeros.
- R2: At a rising clock edge where `cap_ab[h]` is high, the A-to-B register of half h loads `a_in` bits [h*8+7:h*8]. At an edge where `cap_ba[h]` is high, the B-to-A register loads the same bits of `b_in`. At any other edge, each register keeps its value.
- R3: `a_drv[h]` is high exactly when `oe_n[h]` is 0 and `dir[h]` is 0. `b_drv[h]` is high exactly when `oe_n[h]` is 0 and `dir[h]` is 1. When `oe_n[h]` is 1, neither is high.
- R4: While `b_drv[h]` is high, the half-h byte of `b_out` equals the live `a_in` byte when `sel_ab[h]` is 0, and equals the A-to-B register when `sel_ab[h]` is 1.
- R5: While `a_drv[h]` is high, the half-h byte of `a_out` equals the live `b_in` byte when `sel_ba[h]` is 0, and equals the B-to-A register when `sel_ba[h]` is 1.
- R6: When a half is not driving a port, that half's byte of the port's output vector is zero.
- R7: Capture works whatever the values of `oe_n` and `dir`. This includes isolation, and both registers of a half may load at the same edge.
- R8: `a_drv[h]` and `b_drv[h]` are never high together.
- R9: The controls and data of one half have no effect on the outputs or registers of the other half.
- R10: A change of a select, or of live input data, shows on the driven output in the same cycle, with no clock edge needed. Stored-mode output changes only after a capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; capture happens at its rising edge |
| rst | input | 1 | Synchronous active-high reset of the storage registers |
| oe_n | input | N_HALVES | Active-low output enable, one bit per half |
| dir | input | N_HALVES | Direction per half: 1 drives B, 0 drives A |
| cap_ab | input | N_HALVES | Capture strobe for the A-to-B register |
| cap_ba | input | N_HALVES | Capture strobe for the B-to-A register |
| sel_ab | input | N_HALVES | B-port source: 0 live A, 1 stored A-to-B word |
| sel_ba | input | N_HALVES | A-port source: 0 live B, 1 stored B-to-A word |
| a_in | input | HALF_W*N_HALVES | Value currently on the A pins |
| b_in | input | HALF_W*N_HALVES | Value currently on the B pins |
| a_out | output | HALF_W*N_HALVES | Value to drive onto the A pins |
| b_out | output | HALF_W*N_HALVES | Value to drive onto the B pins |
| a_drv | output | N_HALVES | Drive enable of the A pins per half |
| b_drv | output | N_HALVES | Drive enable of the B pins per half |

## Verification
The hardest case to reach is a register that is loaded in one configuration and read back in another. For example, a word is captured while the half is isolated or is driving the opposite port, and only later replayed in stored mode. The sweep varies all six controls of each half on every clock, using different control sequences for the two halves. This creates many capture-then-replay pairs separated by unrelated configurations. Directed steps add two more cases: a select flipped in the middle of a cycle with no edge between the two samples, and a capture strobe held while the live data changes just before the edge.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    localparam int unsigned HALF_W_DEF   = 8;
    localparam int unsigned N_HALVES_DEF = 2;

    // Which port of a half is driven
    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_A    = 2'd1,
        PORT_B    = 2'd2
    } drive_e;

    // Control bundle for one half
    typedef struct packed {
        logic oe_n;
        logic dir;
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
    } half_ctrl_t;

    function automatic drive_e pick_port(input logic oe_n, input logic dir);
        drive_e p;
        if (oe_n)     p = PORT_NONE;
        else if (dir) p = PORT_B;
        else          p = PORT_A;
        return p;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/xcvr_src_mux.sv
`timescale 1ns/1ps
module xcvr_src_mux #(
    parameter int unsigned W = 8
) (
    input  logic         drive,
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    always_comb begin
        if (!drive)          y = '0;
        else if (use_stored) y = stored;
        else                 y = live;
    end

endmodule

// File: rtl/xcvr_half.sv
`timescale 1ns/1ps
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int unsigned W = HALF_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  half_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv
);

    drive_e       port_sel;
    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    assign port_sel = pick_port(ctrl.oe_n, ctrl.dir);
    assign a_drv    = (port_sel == PORT_A);
    assign b_drv    = (port_sel == PORT_B);

    // Capture is not gated by the output controls
    xcvr_store_reg #(.W(W)) u_reg_ab (
        .clk (clk),
        .rst (rst),
        .load(ctrl.cap_ab),
        .d   (a_in),
        .q   (ab_q)
    );

    xcvr_store_reg #(.W(W)) u_reg_ba (
        .clk (clk),
        .rst (rst),
        .load(ctrl.cap_ba),
        .d   (b_in),
        .q   (ba_q)
    );

    xcvr_src_mux #(.W(W)) u_mux_b (
        .drive     (b_drv),
        .use_stored(ctrl.sel_ab),
        .live      (a_in),
        .stored    (ab_q),
        .y         (b_out)
    );

    xcvr_src_mux #(.W(W)) u_mux_a (
        .drive     (a_drv),
        .use_stored(ctrl.sel_ba),
        .live      (b_in),
        .stored    (ba_q),
        .y         (a_out)
    );

endmodule

// File: rtl/xcvr_bidir_top.sv
`timescale 1ns/1ps
module xcvr_bidir_top
    import xcvr_pkg::*;
#(
    parameter int unsigned HALF_W   = HALF_W_DEF,
    parameter int unsigned N_HALVES = N_HALVES_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_HALVES-1:0]        oe_n,
    input  logic [N_HALVES-1:0]        dir,
    input  logic [N_HALVES-1:0]        cap_ab,
    input  logic [N_HALVES-1:0]        cap_ba,
    input  logic [N_HALVES-1:0]        sel_ab,
    input  logic [N_HALVES-1:0]        sel_ba,
    input  logic [HALF_W*N_HALVES-1:0] a_in,
    input  logic [HALF_W*N_HALVES-1:0] b_in,
    output logic [HALF_W*N_HALVES-1:0] a_out,
    output logic [HALF_W*N_HALVES-1:0] b_out,
    output logic [N_HALVES-1:0]        a_drv,
    output logic [N_HALVES-1:0]        b_drv
);

    localparam int unsigned BUS_W = HALF_W * N_HALVES;

    half_ctrl_t ctrl [N_HALVES];

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        assign ctrl[h] = '{
            oe_n:   oe_n[h],
            dir:    dir[h],
            cap_ab: cap_ab[h],
            cap_ba: cap_ba[h],
            sel_ab: sel_ab[h],
            sel_ba: sel_ba[h]
        };

        xcvr_half #(.W(HALF_W)) u_half (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl[h]),
            .a_in (a_in[h*HALF_W +: HALF_W]),
            .b_in (b_in[h*HALF_W +: HALF_W]),
            .a_out(a_out[h*HALF_W +: HALF_W]),
            .b_out(b_out[h*HALF_W +: HALF_W]),
            .a_drv(a_drv[h]),
            .b_drv(b_drv[h])
        );
    end

    if (BUS_W == 0) begin : g_bad_cfg
        initial $error("xcvr_bidir_top: zero bus width");
    end

endmodule

// File: rtl/xcvr_bidir_chk.sv
`timescale 1ns/1ps
module xcvr_bidir_chk #(
    parameter int unsigned HALF_W   = 8,
    parameter int unsigned N_HALVES = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [N_HALVES-1:0]        oe_n,
    input logic [N_HALVES-1:0]        dir,
    input logic [N_HALVES-1:0]        cap_ab,
    input logic [N_HALVES-1:0]        cap_ba,
    input logic [N_HALVES-1:0]        sel_ab,
    input logic [N_HALVES-1:0]        sel_ba,
    input logic [HALF_W*N_HALVES-1:0] a_in,
    input logic [HALF_W*N_HALVES-1:0] b_in,
    input logic [HALF_W*N_HALVES-1:0] a_out,
    input logic [HALF_W*N_HALVES-1:0] b_out,
    input logic [N_HALVES-1:0]        a_drv,
    input logic [N_HALVES-1:0]        b_drv
);

    for (genvar h = 0; h < N_HALVES; h++) begin : g_chk
        AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
            !(a_drv[h] && b_drv[h])); // R8

        AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            oe_n[h] |-> (!a_drv[h] && !b_drv[h])); // R3

        AST_DRIVE_B: assert property (@(posedge clk) disable iff (rst)
            (!oe_n[h] && dir[h]) |-> b_drv[h]); // R3

        AST_LIVE_B: assert property (@(posedge clk) disable iff (rst)
            (b_drv[h] && !sel_ab[h]) |-> (b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W])); // R4

        AST_LIVE_A: assert property (@(posedge clk) disable iff (rst)
            (a_drv[h] && !sel_ba[h]) |-> (a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W])); // R5

        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !a_drv[h] |-> (a_out[h*HALF_W +: HALF_W] == '0)); // R6

        AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (rst)
            ($past(cap_ab[h]) && !$past(rst) && b_drv[h] && sel_ab[h])
                |-> (b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]))); // R2

        AST_STORED_HOLD: assert property (@(posedge clk) disable iff (rst)
            (b_drv[h] && sel_ab[h] && $past(b_drv[h] && sel_ab[h] && !cap_ab[h] && !rst))
                |-> $stable(b_out[h*HALF_W +: HALF_W])); // R10
    end

endmodule

bind xcvr_bidir_top xcvr_bidir_chk #(
    .HALF_W  (HALF_W),
    .N_HALVES(N_HALVES)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (oe_n),
    .dir   (dir),
    .cap_ab(cap_ab),
    .cap_ba(cap_ba),
    .sel_ab(sel_ab),
    .sel_ba(sel_ba),
    .a_in  (a_in),
    .b_in  (b_in),
    .a_out (a_out),
    .b_out (b_out),
    .a_drv (a_drv),
    .b_drv (b_drv)
);

// File: tb/test_xcvr_bidir_top.sv
`timescale 1ns/1ps
module test_xcvr_bidir_top;

    localparam int HW = 8;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NH-1:0] oe_n   = '1;
    logic [NH-1:0] dir    = '0;
    logic [NH-1:0] cap_ab = '0;
    logic [NH-1:0] cap_ba = '0;
    logic [NH-1:0] sel_ab = '0;
    logic [NH-1:0] sel_ba = '0;
    logic [W-1:0]  a_in   = '0;
    logic [W-1:0]  b_in   = '0;
    logic [W-1:0]  a_out;
    logic [W-1:0]  b_out;
    logic [NH-1:0] a_drv;
    logic [NH-1:0] b_drv;

    logic [HW-1:0] m_ab [NH];
    logic [HW-1:0] m_ba [NH];

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xcvr_bidir_top #(.HALF_W(HW), .N_HALVES(NH)) i_xcvr_bidir_top (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .a_drv(a_drv), .b_drv(b_drv)
    );

    // Reference registers built from R1, R2 and R7
    always @(posedge clk) begin
        for (int h = 0; h < NH; h++) begin
            if (rst) begin
                m_ab[h] <= '0;
                m_ba[h] <= '0;
            end else begin
                if (cap_ab[h]) m_ab[h] <= a_in[h*HW +: HW];
                if (cap_ba[h]) m_ba[h] <= b_in[h*HW +: HW];
            end
        end
    end

    task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_half(input int h);
        logic          ea, eb;
        logic [HW-1:0] exp_a, exp_b;
        ea = !oe_n[h] && !dir[h];
        eb = !oe_n[h] &&  dir[h];
        exp_b = !eb ? '0 : (sel_ab[h] ? m_ab[h] : a_in[h*HW +: HW]);
        exp_a = !ea ? '0 : (sel_ba[h] ? m_ba[h] : b_in[h*HW +: HW]);
        chk("R3 a_drv", {7'd0, a_drv[h]}, {7'd0, ea});
        chk("R3 b_drv", {7'd0, b_drv[h]}, {7'd0, eb});
        chk("R8 both drivers", {7'd0, a_drv[h] & b_drv[h]}, 8'd0);
        chk(!eb ? "R6 b_out idle" : "R4 b_out", b_out[h*HW +: HW], exp_b);
        chk(!ea ? "R6 a_out idle" : "R5 a_out", a_out[h*HW +: HW], exp_a);
    endtask

    task automatic set_half(input int h, input logic [5:0] c);
        oe_n[h]   = c[0];
        dir[h]    = c[1];
        cap_ab[h] = c[2];
        cap_ba[h] = c[3];
        sel_ab[h] = c[4];
        sel_ba[h] = c[5];
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        a_in = 16'hA55A;
        b_in = 16'h3CC3;
        cap_ab = '1;
        cap_ba = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cap_ab = '0;
        cap_ba = '0;

        // R1: stored-mode output is zero right after reset
        oe_n = '0; dir = '1; sel_ab = '1;
        #1;
        chk("R1 stored B half0", b_out[7:0], 8'h00);
        chk("R1 stored B half1", b_out[15:8], 8'h00);
        dir = '0; sel_ba = '1;
        #1;
        chk("R1 stored A half0", a_out[7:0], 8'h00);
        chk("R1 stored A half1", a_out[15:8], 8'h00);

        // R7: capture both registers while isolated, then replay
        @(negedge clk);
        oe_n = '1; cap_ab = '1; cap_ba = '1;
        a_in = 16'h1234; b_in = 16'h5678;
        @(negedge clk);
        cap_ab = '0; cap_ba = '0;
        a_in = 16'h0000; b_in = 16'h0000;
        #1;
        chk("R7 isolated A idle", a_out[7:0], 8'h00);
        oe_n = '0; dir = '1; sel_ab = '1;
        #1;
        chk("R7 replay B half0", b_out[7:0], 8'h34);
        chk("R7 replay B half1", b_out[15:8], 8'h12);
        dir = '0; sel_ba = '1;
        #1;
        chk("R7 replay A half0", a_out[7:0], 8'h78);

        // R10: select flip without a clock edge, live change, stored hold before edge
        @(negedge clk);
        dir = '1; sel_ab = '0; a_in = 16'h00C7;
        #0.5;
        chk("R10 live B", b_out[7:0], 8'hC7);
        sel_ab[0] = 1'b1;
        #0.5;
        chk("R10 select to stored", b_out[7:0], 8'h34);
        cap_ab[0] = 1'b1;
        a_in = 16'h00E1;
        #0.5;
        chk("R10 stored before edge", b_out[7:0], 8'h34);
        @(negedge clk);
        cap_ab[0] = 1'b0;
        #0.5;
        chk("R2 stored after edge", b_out[7:0], 8'hE1);

        // R9: half1 isolated and capturing while half0 drives B
        @(negedge clk);
        oe_n = 2'b10; dir = 2'b11; sel_ab = 2'b00;
        cap_ab = 2'b10; cap_ba = 2'b10;
        a_in = 16'h9966; b_in = 16'hAA55;
        #1;
        chk("R9 half1 B idle", b_out[15:8], 8'h00);
        chk("R9 half1 drv", {6'd0, a_drv[1], b_drv[1]}, 8'h00);
        chk("R9 half0 live", b_out[7:0], 8'h66);
        @(negedge clk);
        cap_ab = '0; cap_ba = '0;
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b01; sel_ba = 2'b10;
        #1;
        chk("R9 half0 stored kept", b_out[7:0], 8'hE1);
        chk("R9 half1 captured", a_out[15:8], 8'hAA);

        // Sweep: R2..R6, R8, R9 with unrelated control patterns per half
        for (int i = 0; i < 512; i++) begin
            logic [15:0] k0, k1;
            @(negedge clk);
            k0 = 16'(i);
            k1 = 16'(i * 13 + 5);
            set_half(0, k0[5:0]);
            set_half(1, k1[5:0]);
            a_in = 16'(i * 37 + 11);
            b_in = 16'(i * 91 + 200);
            #1;
            for (int h = 0; h < NH; h++) chk_half(h);
        end

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule